// File: doc/BRIEF.md
# NAND Feature Register Access Sequencer

This block runs the two feature-register operations of an 8-bit asynchronous NAND flash device. A host offers one request: an operation selector (write a feature or read it back), a feature address byte and a 32-bit parameter word. The block then generates every bus cycle on the flash pins, waits for the device's ready/busy line, and returns the result. A write sends opcode EFh, the address and four parameter bytes. A read sends opcode EEh and the address, waits for the device, then clocks four bytes back.

The request side follows valid/ready rules. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low for the whole operation, so a caller holding `req_valid` is back-pressured until the block is idle again. The result has no back-pressure. `done` is a one-cycle pulse, and `err` and `rsp_param` stay valid until the next request is taken.

All device timing is set by parameters counted in clock cycles: strobe low and high widths, chip-enable setup, the address-to-data gap, the write-to-busy delay, the read-after-ready delay and the busy timeout. The ready/busy input is synchronised before use. The data pins are split into an output byte, an output enable and an input byte, and the pad ring combines them into the tri-state bus.

Top module: `nand_feat_seq`

## Requirements
- R1: A request is accepted only when `req_valid` and `req_ready` are both high. From then until the cycle `done` pulses, `busy` is high and `req_ready` is low, and `req_valid` has no effect during that time.
- R2: A write operation latches, on successive rising edges of the write strobe, EFh with CLE high, then the feature address with ALE high, then parameter bytes `req_param[7:0]`, `[15:8]`, `[23:16]` and `[31:24]` with CLE and ALE low.
- R3: A read operation latches EEh with CLE high and then the feature address with ALE high. It then issues exactly four read-strobe pulses, sampling DQ on each rising edge of RE#; the first byte lands in `rsp_param[7:0]` and the fourth in `rsp_param[31:24]`.
- R4: CLE and ALE are never high together, and both are low during every parameter byte.
- R5: At least `T_ADL` clock cycles separate the write-strobe rise that latches the address from the write-strobe rise that latches the first parameter byte.
- R6: After the last parameter byte of a write, the block waits `T_WB` cycles and then waits for ready/busy to be high before it pulses `done`.
- R7: In a read, the first falling edge of RE# comes only after ready/busy is seen high, unless the busy timeout has already expired.
- R8: If ready/busy stays low for `T_TIMEOUT` cycles of waiting, `err` is set, the operation continues to completion, and `err` stays set until the next request is accepted, which clears it.
- R9: `nand_dq_oe` is high only during command, address and parameter-write cycles. It is never high while RE# is low or while the block is idle.
- R10: While in reset and right after it, CE#, WE# and RE# are high, CLE, ALE, `nand_dq_oe`, `busy`, `done` and `err` are low, and `req_ready` is high.
- R11: CE# is low from the start of an operation's command setup until its last cycle, and it is low whenever WE# or RE# is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_get | input | 1 | 1 = read feature, 0 = write feature |
| req_addr | input | 8 | Feature address |
| req_param | input | 32 | Parameter bytes for a write, byte 0 in bits 7:0 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Busy timeout occurred in the last operation |
| rsp_param | output | 32 | Bytes read by the last read, byte 0 in bits 7:0 |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Data byte driven to the device |
| nand_dq_oe | output | 1 | Drive enable for the data pins |
| nand_dq_in | input | 8 | Data byte from the device |
| nand_rb_n | input | 1 | Ready (1) / busy (0) from the device |

## Verification
The hardest case to reach is the busy timeout. The block only sees it when the device holds ready/busy low for longer than the timeout window, and a well-behaved device never does that. The bench device model has a stuck-busy switch that stretches the busy interval past `T_TIMEOUT`. This is used on both a write and a read, so the bench can show that the read bytes still arrive with `err` set. A following normal read then shows that the error clears and that the timed-out write still stored its bytes.

// File: rtl/nand_feat_pkg.sv
package nand_feat_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CSETUP, ST_CMD, ST_ADDR, ST_ADLGAP, ST_DIN,
    ST_WBWAIT, ST_RBWAIT, ST_RRGAP, ST_DOUT, ST_DONE
  } seq_state_e;

  typedef enum logic [1:0] {
    CYC_CMD, CYC_ADDR, CYC_DIN, CYC_DOUT
  } cyc_kind_e;

  localparam logic [7:0] OPC_FEAT_WR = 8'hEF;
  localparam logic [7:0] OPC_FEAT_RD = 8'hEE;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/nand_wait_ctr.sv
module nand_wait_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/nand_bus_cycle.sv
module nand_bus_cycle
  import nand_feat_pkg::*;
#(
  parameter int T_WP  = 2,
  parameter int T_WH  = 2,
  parameter int T_RP  = 2,
  parameter int T_REH = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      go,
  input  cyc_kind_e kind,
  input  logic [7:0] wbyte,
  input  logic [7:0] dq_in,
  output logic      cle,
  output logic      ale,
  output logic      we_n,
  output logic      re_n,
  output logic [7:0] dq_out,
  output logic      dq_oe,
  output logic [7:0] rbyte,
  output logic      fin
);

  localparam int CMAX = imax(imax(T_WP, T_RP), imax(T_WH, T_REH));
  localparam int CW   = $clog2(CMAX + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_LOW, PH_HIGH} phase_e;

  phase_e    ph_q;
  logic [CW-1:0] cnt_q;
  cyc_kind_e kind_q;
  logic [7:0] byte_q;
  logic      rd;
  logic [CW-1:0] low_last, high_last;

  assign rd        = (kind_q == CYC_DOUT);
  assign low_last  = rd ? CW'(T_RP - 1)  : CW'(T_WP - 1);
  assign high_last = rd ? CW'(T_REH - 1) : CW'(T_WH - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      kind_q <= CYC_CMD;
      byte_q <= '0;
      rbyte  <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: if (go) begin
          ph_q   <= PH_SETUP;
          cnt_q  <= '0;
          kind_q <= kind;
          byte_q <= wbyte;
        end
        PH_SETUP: ph_q <= PH_LOW;
        PH_LOW: begin
          if (cnt_q == low_last) begin
            ph_q  <= PH_HIGH;
            cnt_q <= '0;
            if (rd) rbyte <= dq_in;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_HIGH: begin
          if (cnt_q == high_last) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  logic active;
  assign active = (ph_q != PH_IDLE);
  assign cle    = active && (kind_q == CYC_CMD);
  assign ale    = active && (kind_q == CYC_ADDR);
  assign dq_oe  = active && !rd;
  assign dq_out = dq_oe ? byte_q : 8'h00;
  assign we_n   = !((ph_q == PH_LOW) && !rd);
  assign re_n   = !((ph_q == PH_LOW) && rd);
  assign fin    = (ph_q == PH_HIGH) && (cnt_q == high_last);

  // R2
  go_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (ph_q == PH_IDLE));

  // R3
  rbyte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_LOW) |=> $stable(rbyte));

endmodule

// File: rtl/nand_feat_seq.sv
module nand_feat_seq
  import nand_feat_pkg::*;
#(
  parameter int PARAM_BYTES = 4,
  parameter int SYNC_STAGES = 2,
  parameter int T_CS      = 2,
  parameter int T_WP      = 2,
  parameter int T_WH      = 2,
  parameter int T_RP      = 2,
  parameter int T_REH     = 2,
  parameter int T_ADL     = 9,
  parameter int T_WB      = 13,
  parameter int T_RR      = 3,
  parameter int T_TIMEOUT = 250
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_get,
  input  logic [7:0]  req_addr,
  input  logic [PARAM_BYTES*8-1:0] req_param,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic [PARAM_BYTES*8-1:0] rsp_param,
  output logic        nand_ce_n,
  output logic        nand_cle,
  output logic        nand_ale,
  output logic        nand_we_n,
  output logic        nand_re_n,
  output logic [7:0]  nand_dq_out,
  output logic        nand_dq_oe,
  input  logic [7:0]  nand_dq_in,
  input  logic        nand_rb_n
);

  localparam int PW    = PARAM_BYTES * 8;
  localparam int IDX_W = (PARAM_BYTES > 1) ? $clog2(PARAM_BYTES) : 1;
  localparam int WMAX  = imax(imax(imax(T_CS, T_ADL), imax(T_WB, T_RR)), T_TIMEOUT);
  localparam int CNT_W = $clog2(WMAX + 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(PARAM_BYTES - 1);

  // ready/busy synchroniser
  logic [SYNC_STAGES-1:0] rb_sync_q;
  logic rb_s;
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) rb_sync_q <= '0;
        else        rb_sync_q <= nand_rb_n;
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) rb_sync_q <= '0;
        else        rb_sync_q <= {rb_sync_q[SYNC_STAGES-2:0], nand_rb_n};
    end
  endgenerate
  assign rb_s = rb_sync_q[SYNC_STAGES-1];

  seq_state_e state_q, state_d;
  logic            get_q;
  logic [7:0]      addr_q;
  logic [PW-1:0]   param_q, rsp_q;
  logic [IDX_W-1:0] idx_q;
  logic            err_q, launch_q;

  logic            launch_d, idx_inc, set_err, cap, accept;
  logic            wload, wzero;
  logic [CNT_W-1:0] wval;

  cyc_kind_e  kind;
  logic [7:0] wbyte, rbyte;
  logic       fin;

  always_comb begin
    state_d  = state_q;
    launch_d = 1'b0;
    idx_inc  = 1'b0;
    set_err  = 1'b0;
    cap      = 1'b0;
    accept   = 1'b0;
    wload    = 1'b0;
    wval     = '0;
    case (state_q)
      ST_IDLE: if (req_valid) begin
        accept  = 1'b1;
        state_d = ST_CSETUP;
        wload   = 1'b1;
        wval    = CNT_W'(T_CS);
      end
      ST_CSETUP: if (wzero) begin
        state_d  = ST_CMD;
        launch_d = 1'b1;
      end
      ST_CMD: if (fin) begin
        state_d  = ST_ADDR;
        launch_d = 1'b1;
      end
      ST_ADDR: if (fin) begin
        wload = 1'b1;
        if (get_q) begin
          state_d = ST_WBWAIT;
          wval    = CNT_W'(T_WB);
        end else begin
          state_d = ST_ADLGAP;
          wval    = CNT_W'(T_ADL);
        end
      end
      ST_ADLGAP: if (wzero) begin
        state_d  = ST_DIN;
        launch_d = 1'b1;
      end
      ST_DIN: if (fin) begin
        if (idx_q == IDX_LAST) begin
          state_d = ST_WBWAIT;
          wload   = 1'b1;
          wval    = CNT_W'(T_WB);
        end else begin
          launch_d = 1'b1;
          idx_inc  = 1'b1;
        end
      end
      ST_WBWAIT: if (wzero) begin
        state_d = ST_RBWAIT;
        wload   = 1'b1;
        wval    = CNT_W'(T_TIMEOUT);
      end
      ST_RBWAIT: if (rb_s || wzero) begin
        set_err = !rb_s;
        if (get_q) begin
          state_d = ST_RRGAP;
          wload   = 1'b1;
          wval    = CNT_W'(T_RR);
        end else begin
          state_d = ST_DONE;
        end
      end
      ST_RRGAP: if (wzero) begin
        state_d  = ST_DOUT;
        launch_d = 1'b1;
      end
      ST_DOUT: if (fin) begin
        cap = 1'b1;
        if (idx_q == IDX_LAST) begin
          state_d = ST_DONE;
        end else begin
          launch_d = 1'b1;
          idx_inc  = 1'b1;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      get_q    <= 1'b0;
      addr_q   <= '0;
      param_q  <= '0;
      rsp_q    <= '0;
      idx_q    <= '0;
      err_q    <= 1'b0;
      launch_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      launch_q <= launch_d;
      if (accept) begin
        get_q   <= req_get;
        addr_q  <= req_addr;
        param_q <= req_param;
        rsp_q   <= '0;
        err_q   <= 1'b0;
        idx_q   <= '0;
      end else if (state_q == ST_WBWAIT) begin
        idx_q <= '0;
      end else if (idx_inc) begin
        idx_q <= idx_q + 1'b1;
      end
      if (set_err) err_q <= 1'b1;
      if (cap) rsp_q[idx_q*8 +: 8] <= rbyte;
    end
  end

  always_comb begin
    kind  = CYC_CMD;
    wbyte = get_q ? OPC_FEAT_RD : OPC_FEAT_WR;
    case (state_q)
      ST_ADDR: begin kind = CYC_ADDR; wbyte = addr_q; end
      ST_DIN:  begin kind = CYC_DIN;  wbyte = param_q[idx_q*8 +: 8]; end
      ST_DOUT: begin kind = CYC_DOUT; wbyte = 8'h00; end
      default: ;
    endcase
  end

  nand_wait_ctr #(.W(CNT_W)) u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wload),
    .load_val (wval),
    .zero     (wzero)
  );

  nand_bus_cycle #(
    .T_WP (T_WP), .T_WH (T_WH), .T_RP (T_RP), .T_REH (T_REH)
  ) u_cycle (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (launch_q),
    .kind   (kind),
    .wbyte  (wbyte),
    .dq_in  (nand_dq_in),
    .cle    (nand_cle),
    .ale    (nand_ale),
    .we_n   (nand_we_n),
    .re_n   (nand_re_n),
    .dq_out (nand_dq_out),
    .dq_oe  (nand_dq_oe),
    .rbyte  (rbyte),
    .fin    (fin)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_DONE);
  assign err       = err_q;
  assign rsp_param = rsp_q;
  assign nand_ce_n = (state_q == ST_IDLE) || (state_q == ST_DONE);

  // address-to-data gap monitor
  localparam int GW = $clog2(T_ADL + 2);
  logic          we_prev_q, adl_pend_q;
  logic [GW-1:0] adl_cnt_q;
  logic          we_rise, data_rise;
  assign we_rise   = !we_prev_q && nand_we_n;
  assign data_rise = we_rise && !nand_cle && !nand_ale;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_prev_q  <= 1'b1;
      adl_pend_q <= 1'b0;
      adl_cnt_q  <= '0;
    end else begin
      we_prev_q <= nand_we_n;
      if (we_rise && nand_ale) begin
        adl_pend_q <= 1'b1;
        adl_cnt_q  <= '0;
      end else begin
        if (data_rise) adl_pend_q <= 1'b0;
        if (adl_cnt_q != GW'(T_ADL + 1)) adl_cnt_q <= adl_cnt_q + 1'b1;
      end
    end
  end

  // R1
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  // R4
  cle_ale_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  // R5
  adl_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rise && adl_pend_q) |-> (adl_cnt_q >= GW'(T_ADL)));

  // R6
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rb_s || err_q));

  // R7
  re_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> (rb_s || err_q));

  // R9
  dq_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_re_n || !busy) |-> !nand_dq_oe);

  // R11
  ce_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> !nand_ce_n);

endmodule

// File: tb/nand_feat_seq_test.sv
module nand_feat_seq_test;

  localparam int T_ADL = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 1'b0, req_get = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_param = '0;
  logic        req_ready, busy, done, err;
  logic [31:0] rsp_param;
  logic        ce_n, cle, ale, we_n, re_n, dq_oe;
  logic [7:0]  dq_out, dq_in;
  logic        rb_n = 1'b1;

  nand_feat_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_get(req_get), .req_addr(req_addr), .req_param(req_param),
    .busy(busy), .done(done), .err(err), .rsp_param(rsp_param),
    .nand_ce_n(ce_n), .nand_cle(cle), .nand_ale(ale), .nand_we_n(we_n),
    .nand_re_n(re_n), .nand_dq_out(dq_out), .nand_dq_oe(dq_oe),
    .nand_dq_in(dq_in), .nand_rb_n(rb_n)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard queues
  logic [9:0]  exp_q[$];   // {cle, ale, byte}
  logic [33:0] rsp_q[$];   // {is_get, err, data}
  logic [31:0] shadow [0:255];

  // device model
  logic [7:0] feat [0:255][0:3];
  logic [7:0] m_cmd = '0, m_addr = '0;
  int  m_cnt = 0;
  logic [1:0] rd_idx = '0;
  bit  stuck_mode = 0;
  int  busy_dly = 0, busy_left = 0, busy_count = 0, done_count = 0;
  int  cyc = 0, adl_t = 0;
  logic we_p = 1'b1, re_p = 1'b1;
  int  v_cleale = 0, v_oe = 0, v_ce = 0;

  assign dq_in = feat[m_addr][rd_idx];

  initial begin
    for (int i = 0; i < 256; i++) begin
      shadow[i] = '0;
      for (int j = 0; j < 4; j++) feat[i][j] = '0;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (cle && ale) v_cleale++;
      if (dq_oe && (!re_n || !busy)) v_oe++;
      if ((!we_n || !re_n) && ce_n) v_ce++;
      // busy generator
      if (busy_dly > 0) begin
        busy_dly--;
        if (busy_dly == 0) begin
          rb_n = 1'b0;
          busy_count++;
          busy_left = stuck_mode ? 400 : 30;
        end
      end else if (busy_left > 0) begin
        busy_left--;
        if (busy_left == 0) rb_n = 1'b1;
      end
      // write strobe latch: monitor pops expected bus events (R2, R3, R4)
      if (!we_p && we_n) begin
        if (exp_q.size() == 0) begin
          chk(0, "R2 R3 unexpected latch", {54'd0, cle, ale, dq_out}, 64'd0);
        end else begin
          logic [9:0] e;
          e = exp_q.pop_front();
          chk({cle, ale, dq_out} == e, "R2 R3 R4 bus latch", {54'd0, cle, ale, dq_out}, {54'd0, e});
        end
        if (cle) begin
          m_cmd = dq_out;
          m_cnt = 0;
        end else if (ale) begin
          m_addr = dq_out;
          adl_t = cyc;
          rd_idx = '0;
          if (m_cmd == 8'hEE) busy_dly = 2;
        end else begin
          if (m_cnt == 0)
            chk((cyc - adl_t) >= T_ADL, "R5 address-to-data gap", 64'(cyc - adl_t), 64'(T_ADL));
          if (m_cnt < 4) feat[m_addr][m_cnt] = dq_out;
          m_cnt++;
          if (m_cnt == 4) busy_dly = 2;
        end
      end
      // read strobe
      if (re_p && !re_n)
        chk(rb_n || stuck_mode, "R7 read before ready", {63'd0, rb_n}, 64'd1);
      if (!re_p && re_n) rd_idx = rd_idx + 1'b1;
      // completion
      if (done) begin
        if (rsp_q.size() == 0) begin
          chk(0, "R1 unexpected done", 64'd1, 64'd0);
        end else begin
          logic [33:0] r;
          r = rsp_q.pop_front();
          chk(err == r[32], "R8 error flag", {63'd0, err}, {63'd0, r[32]});
          if (r[33]) chk(rsp_param == r[31:0], "R3 read data", {32'd0, rsp_param}, {32'd0, r[31:0]});
          if (!r[32]) chk(rb_n == 1'b1, "R6 done while busy", {63'd0, rb_n}, 64'd1);
        end
        done_count++;
      end
    end
    we_p = we_n;
    re_p = re_n;
  end

  task automatic run_op(input bit get, input logic [7:0] a, input logic [31:0] p,
                        input bit stuck, input bit noise);
    int dc, bc;
    while (rb_n !== 1'b1 || busy_left != 0 || busy_dly != 0) @(negedge clk);
    stuck_mode = stuck;
    exp_q.push_back({2'b10, get ? 8'hEE : 8'hEF});
    exp_q.push_back({2'b01, a});
    if (!get) for (int i = 0; i < 4; i++) exp_q.push_back({2'b00, p[i*8 +: 8]});
    rsp_q.push_back({get, stuck, get ? shadow[a] : 32'd0});
    if (!get) shadow[a] = p;
    dc = done_count;
    bc = busy_count;
    req_get = get; req_addr = a; req_param = p; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy && !req_ready, "R1 busy after accept", {62'd0, busy, req_ready}, 64'd2);
    if (noise) begin
      req_addr = 8'hFF; req_get = 1'b0; req_param = 32'hFFFF_FFFF; req_valid = 1'b1;
      repeat (10) @(negedge clk);
      req_valid = 1'b0;
    end
    while (done_count == dc) @(negedge clk);
    chk(exp_q.size() == 0, "R2 R3 missing latches", 64'(exp_q.size()), 64'd0);
    chk(busy_count > bc, "R6 busy interval observed", 64'(busy_count - bc), 64'd1);
    @(negedge clk);
    chk(!busy && req_ready && ce_n, "R11 release after done", {61'd0, busy, req_ready, ce_n}, 64'd3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ce_n && we_n && re_n && !cle && !ale && !dq_oe, "R10 pins in reset",
        {58'd0, ce_n, we_n, re_n, cle, ale, dq_oe}, 64'h38);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !err && req_ready, "R10 status after reset",
        {60'd0, busy, done, err, req_ready}, 64'd1);
    chk(!dq_oe && ce_n, "R9 R11 idle bus", {62'd0, dq_oe, ce_n}, 64'd1);

    run_op(1, 8'h90, 32'h0, 0, 0);                 // reads zeros after reset
    run_op(0, 8'h90, 32'h0000_0008, 0, 0);         // enable internal ECC
    run_op(1, 8'h90, 32'h0, 0, 0);
    run_op(0, 8'h90, 32'h0000_0000, 0, 1);         // disable, with request noise (R1)
    run_op(1, 8'h90, 32'h0, 0, 0);
    run_op(0, 8'h01, 32'h4433_2211, 0, 0);
    run_op(1, 8'h01, 32'h0, 0, 1);
    run_op(0, 8'h02, 32'h0000_00A5, 1, 0);         // R8 timeout on write
    run_op(1, 8'h02, 32'h0, 0, 0);                 // R8 error cleared
    run_op(1, 8'h01, 32'h0, 1, 0);                 // R8 timeout on read
    run_op(1, 8'h02, 32'h0, 0, 0);

    chk(v_cleale == 0, "R4 CLE and ALE together", 64'(v_cleale), 64'd0);
    chk(v_oe == 0, "R9 DQ driven out of turn", 64'(v_oe), 64'd0);
    chk(v_ce == 0, "R11 strobe without CE", 64'(v_ce), 64'd0);
    chk(rsp_q.size() == 0, "R1 pending responses", 64'(rsp_q.size()), 64'd0);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule